// File: doc/BRIEF.md
# Asymmetric Width Dual-Port RAM

This block is a dual-port memory that holds a single array of wide words and serves it through two ports of different widths. The wide port reads and writes whole words. The narrow port treats the same storage as a deeper array of smaller words. The wide word is exactly a power-of-two number of narrow words, so the narrow port never needs a divider. It forms the word address by dropping its low address bits, and it uses those dropped bits to pick a lane.

A narrow write copies its data into every lane position. A one-hot lane enable, decoded from the low address bits, then lets only the addressed lane take the value. A narrow read fetches the whole wide word and returns the lane named by the low address bits. Both ports read synchronously with one cycle of latency. Typical uses are width conversion buffers and register files that one side fills word by word and the other side reads piece by piece.

Top module: `asym_dpram`

## Requirements
- R1: After reset, both read data outputs are zero until the first read is taken on that port.
- R2: A wide write stores the full word. A wide read with its enable high returns that word on the wide read output one clock after the read is sampled.
- R3: Narrow address `a` refers to lane `a mod RATIO` of wide word `a / RATIO`. Lane 0 sits in the least significant bits, so lane `k` is bits `[k*NARROW_W +: NARROW_W]`. A narrow read returns that lane one clock after it is sampled.
- R4: A narrow write changes only the addressed lane of its wide word, and every other lane of that word keeps its value.
- R5: A read and a write on the same port, at the same address in the same cycle, return the data stored before that write.
- R6: A read on one port in the same cycle that the other port writes the same word returns the data stored before that write.
- R7: When both ports write the same wide word in the same cycle, the word afterwards equals the wide write data, and the narrow write has no effect.
- R8: When both ports write different wide words in the same cycle, both writes take effect.
- R9: While a port's read enable is low, that port's read output keeps its last value.
- R10: Both extreme narrow addresses reach their expected locations. The narrow port address is `RATIO`'s log2 bits wider than the wide one. Its all-ones address reaches the top lane of the last wide word, and its address zero reaches lane 0 of word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all activity on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the read output registers |
| wideRdEn | input | 1 | Wide port read enable |
| wideWrEn | input | 1 | Wide port write enable |
| wideAddr | input | WIDE_ADDR_W | Wide port word address |
| wideWrData | input | NARROW_W*RATIO | Wide port write data |
| wideRdData | output | NARROW_W*RATIO | Wide port read data, one cycle latency |
| narrowRdEn | input | 1 | Narrow port read enable |
| narrowWrEn | input | 1 | Narrow port write enable |
| narrowAddr | input | WIDE_ADDR_W+log2(RATIO) | Narrow port address; the low log2(RATIO) bits select the lane |
| narrowWrData | input | NARROW_W | Narrow port write data |
| narrowRdData | output | NARROW_W | Narrow port read data, one cycle latency |

## Verification
The in-design properties assume the enables and addresses are known (not X) at every rising edge once reset is released. The stimulus meets this because it drives every input on the falling edge, from a single task that always assigns all of them. The write-landing properties also assume that storage is not read before it has been written. So the stimulus fills every wide word through the wide port before it issues any read. Collisions between the ports are created only on purpose, by placing both writes, or a read and a write, on the same word in the same cycle.

// File: rtl/asym_dpram_pkg.sv
package asym_dpram_pkg;

  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic wideWr;
    logic wideRd;
    logic narrowWr;
    logic narrowRd;
  } ramStrobes_t;

endpackage

// File: rtl/asym_dpram_ctrl.sv
module asym_dpram_ctrl
  import asym_dpram_pkg::*;
#(
  parameter int RATIO       = 4,
  parameter int WIDE_ADDR_W = 6,
  localparam int LANE_BITS     = $clog2(RATIO),
  localparam int NARROW_ADDR_W = WIDE_ADDR_W + LANE_BITS
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wideRdEn,
  input  logic                     wideWrEn,
  input  logic [WIDE_ADDR_W-1:0]   wideAddr,
  input  logic                     narrowRdEn,
  input  logic                     narrowWrEn,
  input  logic [NARROW_ADDR_W-1:0] narrowAddr,
  output ramStrobes_t              strb,
  output logic [WIDE_ADDR_W-1:0]   narrowWordAddr,
  output logic [LANE_BITS-1:0]     laneSel,
  output logic [RATIO-1:0]         laneEn
);

  logic sameWord;

  // Truncation only: the upper bits are the word, the lower bits the lane
  assign narrowWordAddr = narrowAddr[NARROW_ADDR_W-1:LANE_BITS];
  assign laneSel        = narrowAddr[LANE_BITS-1:0];
  assign sameWord       = (narrowWordAddr == wideAddr);

  always_comb begin
    strb.wideWr   = wideWrEn;
    strb.wideRd   = wideRdEn;
    strb.narrowRd = narrowRdEn;
    // Wide port wins when both write the same word (R7)
    strb.narrowWr = narrowWrEn && !(wideWrEn && sameWord);
  end

  // One-hot lane decode, gated by the narrow write strobe
  for (genvar k = 0; k < RATIO; k++) begin : g_lane
    assign laneEn[k] = strb.narrowWr && (laneSel == LANE_BITS'(k));
  end

  // R4: exactly one lane is enabled for every narrow write
  p_lane_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.narrowWr |-> $countones(laneEn) == 1);

  // R4: no lane is enabled without a narrow write
  p_lane_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !narrowWrEn |-> laneEn == '0);

endmodule

// File: rtl/asym_dpram_data.sv
module asym_dpram_data
  import asym_dpram_pkg::*;
#(
  parameter int NARROW_W    = 9,
  parameter int RATIO       = 4,
  parameter int WIDE_ADDR_W = 6,
  localparam int WIDE_W    = NARROW_W * RATIO,
  localparam int LANE_BITS = $clog2(RATIO),
  localparam int DEPTH     = 1 << WIDE_ADDR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ramStrobes_t            strb,
  input  logic [WIDE_ADDR_W-1:0] wideAddr,
  input  logic [WIDE_W-1:0]      wideWrData,
  input  logic [WIDE_ADDR_W-1:0] narrowWordAddr,
  input  logic [LANE_BITS-1:0]   laneSel,
  input  logic [RATIO-1:0]       laneEn,
  input  logic [NARROW_W-1:0]    narrowWrData,
  output logic [WIDE_W-1:0]      wideRdData,
  output logic [NARROW_W-1:0]    narrowRdData
);

  logic [WIDE_W-1:0]    mem [DEPTH];
  logic [WIDE_W-1:0]    narrowRep;
  logic [WIDE_W-1:0]    narrowWordQ;
  logic [LANE_BITS-1:0] laneQ;

  function automatic logic [NARROW_W-1:0] laneOf(input logic [WIDE_W-1:0] word,
                                                 input logic [LANE_BITS-1:0] lane);
    return word[int'(lane)*NARROW_W +: NARROW_W];
  endfunction

  // Narrow data copied into every lane position
  assign narrowRep = {RATIO{narrowWrData}};

  // Storage: wide write covers the whole word, narrow write one lane
  always_ff @(posedge clk) begin
    if (strb.wideWr) mem[wideAddr] <= wideWrData;
    for (int k = 0; k < RATIO; k++) begin
      if (laneEn[k]) mem[narrowWordAddr][k*NARROW_W +: NARROW_W] <= narrowRep[k*NARROW_W +: NARROW_W];
    end
  end

  // Read registers: old data on same-cycle write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideRdData  <= '0;
      narrowWordQ <= '0;
      laneQ       <= '0;
    end else begin
      if (strb.wideRd) wideRdData <= mem[wideAddr];
      if (strb.narrowRd) begin
        narrowWordQ <= mem[narrowWordAddr];
        laneQ       <= laneSel;
      end
    end
  end

  // Lane select after the register
  assign narrowRdData = laneOf(narrowWordQ, laneQ);

  // R1: reset clears both read outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (wideRdData == '0 && narrowRdData == '0));

  // R9: outputs hold while the read enable is low
  p_wide_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wideRd |=> $stable(wideRdData));
  p_narrow_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.narrowRd |=> $stable(narrowRdData));

  // R7: a wide write always lands in full, even on a collision
  p_wide_lands_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wideWr |=> mem[$past(wideAddr)] == $past(wideWrData));

  // R4: a narrow write lands in the addressed lane
  p_narrow_lands_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.narrowWr |=> laneOf(mem[$past(narrowWordAddr)], $past(laneSel)) == $past(narrowWrData));

endmodule

// File: rtl/asym_dpram.sv
module asym_dpram
  import asym_dpram_pkg::*;
#(
  parameter int NARROW_W    = 9,
  parameter int RATIO       = 4,
  parameter int WIDE_ADDR_W = 6,
  localparam int WIDE_W        = NARROW_W * RATIO,
  localparam int LANE_BITS     = $clog2(RATIO),
  localparam int NARROW_ADDR_W = WIDE_ADDR_W + LANE_BITS
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wideRdEn,
  input  logic                     wideWrEn,
  input  logic [WIDE_ADDR_W-1:0]   wideAddr,
  input  logic [WIDE_W-1:0]        wideWrData,
  output logic [WIDE_W-1:0]        wideRdData,
  input  logic                     narrowRdEn,
  input  logic                     narrowWrEn,
  input  logic [NARROW_ADDR_W-1:0] narrowAddr,
  input  logic [NARROW_W-1:0]      narrowWrData,
  output logic [NARROW_W-1:0]      narrowRdData
);

  // Elaboration-time parameter checks
  if (RATIO < 2 || (RATIO & (RATIO - 1)) != 0) begin : g_bad_ratio
    $error("asym_dpram: RATIO must be a power of two and at least 2");
  end
  if (NARROW_W < 1 || WIDE_ADDR_W < 1) begin : g_bad_size
    $error("asym_dpram: NARROW_W and WIDE_ADDR_W must be positive");
  end

  ramStrobes_t            strb;
  logic [WIDE_ADDR_W-1:0] narrowWordAddr;
  logic [LANE_BITS-1:0]   laneSel;
  logic [RATIO-1:0]       laneEn;

  asym_dpram_ctrl #(
    .RATIO       (RATIO),
    .WIDE_ADDR_W (WIDE_ADDR_W)
  ) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .wideRdEn       (wideRdEn),
    .wideWrEn       (wideWrEn),
    .wideAddr       (wideAddr),
    .narrowRdEn     (narrowRdEn),
    .narrowWrEn     (narrowWrEn),
    .narrowAddr     (narrowAddr),
    .strb           (strb),
    .narrowWordAddr (narrowWordAddr),
    .laneSel        (laneSel),
    .laneEn         (laneEn)
  );

  asym_dpram_data #(
    .NARROW_W    (NARROW_W),
    .RATIO       (RATIO),
    .WIDE_ADDR_W (WIDE_ADDR_W)
  ) u_data (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .wideAddr       (wideAddr),
    .wideWrData     (wideWrData),
    .narrowWordAddr (narrowWordAddr),
    .laneSel        (laneSel),
    .laneEn         (laneEn),
    .narrowWrData   (narrowWrData),
    .wideRdData     (wideRdData),
    .narrowRdData   (narrowRdData)
  );

endmodule

// File: tb/asym_dpram_test.sv
module asym_dpram_test;

  localparam int NW    = 9;
  localparam int RATIO = 4;
  localparam int WAW   = 6;
  localparam int WW    = NW * RATIO;
  localparam int LB    = 2;
  localparam int NAW   = WAW + LB;
  localparam int DEPTH = 1 << WAW;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic           rstN;
  logic           wideRdEn, wideWrEn, narrowRdEn, narrowWrEn;
  logic [WAW-1:0] wideAddr;
  logic [WW-1:0]  wideWrData, wideRdData;
  logic [NAW-1:0] narrowAddr;
  logic [NW-1:0]  narrowWrData, narrowRdData;

  asym_dpram #(.NARROW_W(NW), .RATIO(RATIO), .WIDE_ADDR_W(WAW)) uut (
    .clk(clk), .rstN(rstN),
    .wideRdEn(wideRdEn), .wideWrEn(wideWrEn), .wideAddr(wideAddr),
    .wideWrData(wideWrData), .wideRdData(wideRdData),
    .narrowRdEn(narrowRdEn), .narrowWrEn(narrowWrEn), .narrowAddr(narrowAddr),
    .narrowWrData(narrowWrData), .narrowRdData(narrowRdData)
  );

  // Reference storage built from the requirements
  logic [WW-1:0] model [DEPTH];
  logic [WW-1:0] wLast = '0;   // R1: outputs start at zero
  logic [NW-1:0] nLast = '0;

  logic [WW-1:0] wExpQ[$];
  string         wTagQ[$];
  int            wDueQ[$];
  logic [NW-1:0] nExpQ[$];
  string         nTagQ[$];
  int            nDueQ[$];

  int cycleCnt = 0;
  int nChecks  = 0;
  int nFails   = 0;
  bit finished = 0;

  always @(posedge clk) cycleCnt++;

  function automatic logic [NW-1:0] laneOf(input logic [WW-1:0] w, input int lane);
    return w[lane*NW +: NW];
  endfunction

  function automatic logic [WW-1:0] pattern(input int i);
    logic [WW-1:0] p;
    for (int k = 0; k < RATIO; k++) p[k*NW +: NW] = NW'(((i * RATIO + k) * 37) ^ 'h0A5);
    return p;
  endfunction

  // Driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic step(input bit wr, input bit ww, input int wa, input logic [WW-1:0] wd,
                      input bit nr, input bit nwr, input int na, input logic [NW-1:0] nd,
                      input string tag);
    @(negedge clk);
    wideRdEn = wr; wideWrEn = ww; wideAddr = WAW'(wa); wideWrData = wd;
    narrowRdEn = nr; narrowWrEn = nwr; narrowAddr = NAW'(na); narrowWrData = nd;
    if (wr) wLast = model[wa];                          // old data (R5, R6)
    if (nr) nLast = laneOf(model[na / RATIO], na % RATIO);
    wExpQ.push_back(wLast); wTagQ.push_back(tag); wDueQ.push_back(cycleCnt + 1);
    nExpQ.push_back(nLast); nTagQ.push_back(tag); nDueQ.push_back(cycleCnt + 1);
    if (nwr) model[na / RATIO][(na % RATIO)*NW +: NW] = nd;
    if (ww) model[wa] = wd;                             // wide applied last: wins (R7)
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, '0, 0, 0, 0, '0, tag);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  // Monitor: compares outputs one cycle after each driven cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (wDueQ.size() > 0 && wDueQ[0] == cycleCnt) begin
        nChecks++;
        if (wideRdData !== wExpQ[0]) begin
          nFails++;
          $display("FAIL %s wide read: got %h expected %h", wTagQ[0], wideRdData, wExpQ[0]);
        end
        void'(wExpQ.pop_front()); void'(wTagQ.pop_front()); void'(wDueQ.pop_front());
      end
      while (nDueQ.size() > 0 && nDueQ[0] == cycleCnt) begin
        nChecks++;
        if (narrowRdData !== nExpQ[0]) begin
          nFails++;
          $display("FAIL %s narrow read: got %h expected %h", nTagQ[0], narrowRdData, nExpQ[0]);
        end
        void'(nExpQ.pop_front()); void'(nTagQ.pop_front()); void'(nDueQ.pop_front());
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    report();
  end

  initial begin
    rstN = 1'b0;
    wideRdEn = 0; wideWrEn = 0; wideAddr = '0; wideWrData = '0;
    narrowRdEn = 0; narrowWrEn = 0; narrowAddr = '0; narrowWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: zero outputs before any read
    idle("R1");
    idle("R1");

    // R2: fill through the wide port, then read back
    for (int i = 0; i < DEPTH; i++) step(0, 1, i, pattern(i), 0, 0, 0, '0, "R2");
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 0, i, '0, 0, 0, 0, '0, "R2");
      if (i % 8 == 7) idle("R9");   // R9: outputs hold with enables low
    end

    // R3: every narrow address maps to its lane
    for (int a = 0; a < DEPTH * RATIO; a++) step(0, 0, 0, '0, 1, 0, a, '0, "R3");
    idle("R9");

    // R4: narrow writes touch only their lane
    step(0, 0, 0, '0, 0, 1, 10*RATIO + 1, 9'h1AB, "R4");
    step(0, 0, 0, '0, 0, 1, 10*RATIO + 3, 9'h055, "R4");
    step(1, 0, 10, '0, 1, 0, 10*RATIO + 1, '0, "R4");
    step(0, 0, 0, '0, 1, 0, 10*RATIO + 2, '0, "R4");

    // R5: same-port read during write returns old data
    step(1, 1, 12, 36'h123456789, 0, 0, 0, '0, "R5");
    step(1, 0, 12, '0, 0, 0, 0, '0, "R5");
    step(0, 0, 0, '0, 1, 1, 50, 9'h0F0, "R5");
    step(0, 0, 0, '0, 1, 0, 50, '0, "R5");

    // R6: cross-port read during write returns old data
    step(0, 1, 20, 36'hFEDCBA987, 1, 0, 20*RATIO + 2, '0, "R6");
    step(1, 0, 21, '0, 0, 1, 21*RATIO + 2, 9'h0C3, "R6");
    step(1, 0, 21, '0, 1, 0, 20*RATIO + 2, '0, "R6");

    // R7: collision on one word, wide port wins
    step(0, 1, 30, 36'hA5A5A5A5A, 0, 1, 30*RATIO + 1, 9'h1FF, "R7");
    step(1, 0, 30, '0, 1, 0, 30*RATIO + 1, '0, "R7");

    // R8: different words written together
    step(0, 1, 31, 36'h0F0F0F0F0, 0, 1, 32*RATIO + 2, 9'h18E, "R8");
    step(1, 0, 32, '0, 1, 0, 32*RATIO + 2, '0, "R8");
    step(1, 0, 31, '0, 0, 0, 0, '0, "R8");

    // R10: extreme narrow addresses
    step(0, 0, 0, '0, 0, 1, DEPTH*RATIO - 1, 9'h133, "R10");
    step(1, 0, DEPTH - 1, '0, 1, 0, DEPTH*RATIO - 1, '0, "R10");
    step(0, 0, 0, '0, 0, 1, 0, 9'h066, "R10");
    step(1, 0, 0, '0, 1, 0, 0, '0, "R10");

    idle("R9");
    idle("R9");
    repeat (3) @(negedge clk);
    report();
  end

endmodule